// File: doc/BRIEF.md
# Luma/Chroma Sample Timing Aligner

The block takes a luma sample stream and a chroma sample stream that arrive on the same clock. It gives each stream its own programmable delay so that the two line up at the output. Luma moves in single clock steps. Chroma moves only in chroma pixel steps of two clocks, because by this point in the datapath chroma is already demodulated. Each path has a fixed baseline delay, and an "early" setting is made by tapping that path shorter than its baseline.

The offsets come from one of two places. In manual mode a 2-bit luma code and a 3-bit chroma code set them directly. In automatic mode the manual codes are ignored and the offsets follow the selected input format (composite, separate Y/C, or component). The selected delays are registered, so a new setting applies from the next clock. The delay lines are never flushed, and a change taps history that is already in flight.

Top module: `lcta_align`

## Requirements
- R1: In manual mode (`auto_i`=0) the luma delay follows `lta_i`: 00 gives the 2-clock baseline, 01 gives 3 clocks (one late), 10 gives 0 clocks (two early) and 11 gives 1 clock (one early).
- R2: In manual mode the chroma delay follows `cta_i`, in steps of two clocks around a baseline of 4 clocks: 001 gives 0, 010 gives 2, 011 gives 4, 100 gives 6, 101 gives 8 and 110 gives 10 clocks.
- R3: The unused chroma codes 000 and 111 behave exactly as 011 (4-clock baseline).
- R4: In automatic mode (`auto_i`=1) `lta_i` and `cta_i` have no effect. `fmt_i` selects the setting: 00 composite gives luma code 00 and chroma code 011, 01 Y/C gives 01 and 101, 10 component gives 01 and 110, and 11 is treated as composite.
- R5: Reset is asynchronous and active low. While reset is held, both outputs are 0, and the delay settings return to the automatic composite values (luma 2 clocks, chroma 4 clocks).
- R6: A settings change sampled at one clock edge selects the new delay from that edge onward. The delay lines keep their contents, so the output at once shows the sample that entered the new number of clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_i | input | 1 | 1 selects offsets from the format, 0 selects the manual codes |
| fmt_i | input | 2 | Input format: 00 composite, 01 Y/C, 10 component, 11 as composite |
| lta_i | input | 2 | Manual luma offset code |
| cta_i | input | 3 | Manual chroma offset code |
| luma_i | input | DATA_W | Luma sample in |
| chroma_i | input | DATA_W | Chroma sample in |
| luma_o | output | DATA_W | Delayed luma sample |
| chroma_o | output | DATA_W | Delayed chroma sample |

## Verification
The bench drives every manual code, both unused chroma codes and every format in automatic mode while the manual codes toggle randomly. It then switches settings at random mid-stream and compares each output against its own history of the inputs on every cycle. A design that swapped the asymmetric luma encodings, or that moved chroma by one clock per step, would hand back the wrong sample from history at once. The same holds for a design that let the manual codes leak through in automatic mode, or that left the unused chroma codes to select some other delay. A design that flushed its lines on a change, or applied the change a cycle late, would fail on the cycles right after each switch. The zero-clock luma setting checks that the tap passes the current input straight through.

// File: rtl/lcta_pkg.sv
package lcta_pkg;

  typedef enum logic [1:0] {
    FMT_CVBS  = 2'd0,
    FMT_YC    = 2'd1,
    FMT_YPBPR = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  // signed luma offset in clocks relative to baseline
  function automatic int luma_offset(input logic [1:0] code);
    case (code)
      2'b01:   return 1;
      2'b10:   return -2;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  // signed chroma offset in chroma steps relative to baseline
  function automatic int chroma_offset(input logic [2:0] code);
    case (code)
      3'b001:  return -2;
      3'b010:  return -1;
      3'b100:  return 1;
      3'b101:  return 2;
      3'b110:  return 3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/lcta_delay_line.sv
module lcta_delay_line #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 3,
  localparam int SEL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);

  logic [DATA_W-1:0] sr_q [DEPTH];
  logic [DATA_W-1:0] taps [DEPTH+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign taps[0] = din_i;
  for (genvar k = 1; k <= DEPTH; k++) begin : g_tap
    assign taps[k] = sr_q[k-1];
  end

  always_comb begin
    if (int'(sel_i) > DEPTH) dout_o = taps[DEPTH];
    else                     dout_o = taps[sel_i];
  end

endmodule

// File: rtl/lcta_cfg_sel.sv
module lcta_cfg_sel
  import lcta_pkg::*;
#(
  parameter int LUMA_BASE         = 2,
  parameter int CHROMA_BASE_STEPS = 2,
  parameter int STEP_CLKS         = 2,
  localparam int LUMA_DEPTH   = LUMA_BASE + 1,
  localparam int CHROMA_DEPTH = (CHROMA_BASE_STEPS + 3) * STEP_CLKS,
  localparam int LUMA_SEL_W   = $clog2(LUMA_DEPTH + 1),
  localparam int CHROMA_SEL_W = $clog2(CHROMA_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    auto_i,
  input  logic [1:0]              fmt_i,
  input  logic [1:0]              lta_i,
  input  logic [2:0]              cta_i,
  output logic [LUMA_SEL_W-1:0]   luma_dly_o,
  output logic [CHROMA_SEL_W-1:0] chroma_dly_o
);

  logic [1:0] lta_eff;
  logic [2:0] cta_eff;
  logic [LUMA_SEL_W-1:0]   luma_dly_d;
  logic [CHROMA_SEL_W-1:0] chroma_dly_d;

  always_comb begin
    lta_eff = lta_i;
    cta_eff = cta_i;
    if (auto_i) begin
      case (fmt_e'(fmt_i))
        FMT_YC:    begin lta_eff = 2'b01; cta_eff = 3'b101; end
        FMT_YPBPR: begin lta_eff = 2'b01; cta_eff = 3'b110; end
        default:   begin lta_eff = 2'b00; cta_eff = 3'b011; end
      endcase
    end
    luma_dly_d   = LUMA_SEL_W'(LUMA_BASE + luma_offset(lta_eff));
    chroma_dly_d = CHROMA_SEL_W'((CHROMA_BASE_STEPS + chroma_offset(cta_eff)) * STEP_CLKS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      luma_dly_o   <= LUMA_SEL_W'(LUMA_BASE);
      chroma_dly_o <= CHROMA_SEL_W'(CHROMA_BASE_STEPS * STEP_CLKS);
    end else begin
      luma_dly_o   <= luma_dly_d;
      chroma_dly_o <= chroma_dly_d;
    end
  end

endmodule

// File: rtl/lcta_align.sv
module lcta_align #(
  parameter int DATA_W            = 10,
  parameter int LUMA_BASE         = 2,
  parameter int CHROMA_BASE_STEPS = 2,
  parameter int STEP_CLKS         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        lta_i,
  input  logic [2:0]        cta_i,
  input  logic [DATA_W-1:0] luma_i,
  input  logic [DATA_W-1:0] chroma_i,
  output logic [DATA_W-1:0] luma_o,
  output logic [DATA_W-1:0] chroma_o
);

  localparam int LUMA_DEPTH   = LUMA_BASE + 1;
  localparam int CHROMA_DEPTH = (CHROMA_BASE_STEPS + 3) * STEP_CLKS;
  localparam int LUMA_SEL_W   = $clog2(LUMA_DEPTH + 1);
  localparam int CHROMA_SEL_W = $clog2(CHROMA_DEPTH + 1);

  logic [LUMA_SEL_W-1:0]   luma_dly;
  logic [CHROMA_SEL_W-1:0] chroma_dly;

  lcta_cfg_sel #(
    .LUMA_BASE(LUMA_BASE),
    .CHROMA_BASE_STEPS(CHROMA_BASE_STEPS),
    .STEP_CLKS(STEP_CLKS)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .auto_i(auto_i), .fmt_i(fmt_i), .lta_i(lta_i), .cta_i(cta_i),
    .luma_dly_o(luma_dly), .chroma_dly_o(chroma_dly)
  );

  lcta_delay_line #(.DATA_W(DATA_W), .DEPTH(LUMA_DEPTH)) u_luma_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(luma_dly),
    .din_i(luma_i), .dout_o(luma_o)
  );

  lcta_delay_line #(.DATA_W(DATA_W), .DEPTH(CHROMA_DEPTH)) u_chroma_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(chroma_dly),
    .din_i(chroma_i), .dout_o(chroma_o)
  );

endmodule

// File: rtl/lcta_align_chk.sv
module lcta_align_chk #(
  parameter int DATA_W            = 10,
  parameter int LUMA_BASE         = 2,
  parameter int CHROMA_BASE_STEPS = 2,
  parameter int STEP_CLKS         = 2,
  localparam int LUMA_SEL_W   = $clog2(LUMA_BASE + 2),
  localparam int CHROMA_SEL_W = $clog2((CHROMA_BASE_STEPS + 3) * STEP_CLKS + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    auto_i,
  input logic [1:0]              fmt_i,
  input logic [1:0]              lta_i,
  input logic [2:0]              cta_i,
  input logic [DATA_W-1:0]       luma_i,
  input logic [DATA_W-1:0]       chroma_i,
  input logic [DATA_W-1:0]       luma_o,
  input logic [DATA_W-1:0]       chroma_o,
  input logic [LUMA_SEL_W-1:0]   luma_dly,
  input logic [CHROMA_SEL_W-1:0] chroma_dly
);

  localparam int CBASE = CHROMA_BASE_STEPS * STEP_CLKS;

  logic [3:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 4'hf)  cyc_q <= cyc_q + 4'd1;
  end

  a_r1_luma_two_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd3 && int'(luma_dly) == 2) |-> luma_o == $past(luma_i, 2));

  a_r1_luma_zero_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (luma_dly == '0) |-> luma_o == luma_i);

  a_r2_chroma_four_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd5 && int'(chroma_dly) == 4) |-> chroma_o == $past(chroma_i, 4));

  a_r3_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd1 && !$past(auto_i) && ($past(cta_i) == 3'b000 || $past(cta_i) == 3'b111))
    |-> int'(chroma_dly) == CBASE);

  a_r4_auto_component: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd1 && $past(auto_i) && $past(fmt_i) == 2'b10)
    |-> (int'(luma_dly) == LUMA_BASE + 1 && int'(chroma_dly) == CBASE + 3 * STEP_CLKS));

  a_r6_next_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd1 && $past(auto_i) && $past(fmt_i) == 2'b00)
    |-> (int'(luma_dly) == LUMA_BASE && int'(chroma_dly) == CBASE));

endmodule

bind lcta_align lcta_align_chk #(
  .DATA_W(DATA_W),
  .LUMA_BASE(LUMA_BASE),
  .CHROMA_BASE_STEPS(CHROMA_BASE_STEPS),
  .STEP_CLKS(STEP_CLKS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .auto_i(auto_i), .fmt_i(fmt_i),
  .lta_i(lta_i), .cta_i(cta_i), .luma_i(luma_i), .chroma_i(chroma_i),
  .luma_o(luma_o), .chroma_o(chroma_o),
  .luma_dly(luma_dly), .chroma_dly(chroma_dly)
);

// File: tb/lcta_align_tb.sv
module lcta_align_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 10;
  localparam int NHIST      = 8192;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          auto_i = 1'b1;
  logic [1:0]    fmt_i = 2'b00;
  logic [1:0]    lta_i = 2'b00;
  logic [2:0]    cta_i = 3'b011;
  logic [DW-1:0] luma_i = '0;
  logic [DW-1:0] chroma_i = '0;
  logic [DW-1:0] luma_o, chroma_o;

  int checks = 0;
  int errors = 0;
  int j = 0;
  logic [DW-1:0] yh [NHIST];
  logic [DW-1:0] ch [NHIST];
  bit         p_auto = 1'b1;
  logic [1:0] p_fmt  = 2'b00;
  logic [1:0] p_lta  = 2'b00;
  logic [2:0] p_cta  = 3'b011;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcta_align u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_i(auto_i), .fmt_i(fmt_i),
    .lta_i(lta_i), .cta_i(cta_i), .luma_i(luma_i), .chroma_i(chroma_i),
    .luma_o(luma_o), .chroma_o(chroma_o)
  );

  // expected delays in clocks, from the requirement tables
  function automatic int exp_luma(bit a, logic [1:0] f, logic [1:0] l);
    if (a) return (f == 2'b01 || f == 2'b10) ? 3 : 2;
    case (l)
      2'b00: return 2;
      2'b01: return 3;
      2'b10: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_chroma(bit a, logic [1:0] f, logic [2:0] c);
    if (a) begin
      if (f == 2'b01) return 8;
      if (f == 2'b10) return 10;
      return 4;
    end
    case (c)
      3'b001: return 0;
      3'b010: return 2;
      3'b100: return 6;
      3'b101: return 8;
      3'b110: return 10;
      default: return 4;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (step %0d)", tag, what, act, exp, j);
    end
  endtask

  task automatic step(bit a, logic [1:0] f, logic [1:0] l, logic [2:0] c, string tag);
    int dl, dc;
    @(negedge clk);
    auto_i = a; fmt_i = f; lta_i = l; cta_i = c;
    yh[j] = DW'($urandom);
    ch[j] = DW'($urandom);
    luma_i = yh[j];
    chroma_i = ch[j];
    #1;
    dl = exp_luma(p_auto, p_fmt, p_lta);
    dc = exp_chroma(p_auto, p_fmt, p_cta);
    check(tag, "luma", luma_o, (j >= dl) ? yh[j-dl] : '0);
    check(tag, "chroma", chroma_o, (j >= dc) ? ch[j-dc] : '0);
    p_auto = a; p_fmt = f; p_lta = l; p_cta = c;
    j++;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a17));
    luma_i = 10'd5;
    chroma_i = 10'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5", "luma in reset", luma_o, '0);
    check("R5", "chroma in reset", chroma_o, '0);
    luma_i = '0;
    chroma_i = '0;
    rst_ni = 1'b1;
    // R5: defaults after reset give 2/4 clock delays
    repeat (12) step(1'b1, 2'b00, 2'b00, 3'b011, "R5");
    // R1: every manual luma code
    for (int l = 0; l < 4; l++)
      repeat (16) step(1'b0, 2'b00, 2'(l), 3'b011, "R1");
    // R2 / R3: every manual chroma code
    for (int c = 0; c < 8; c++)
      repeat (16) step(1'b0, 2'b00, 2'b00, 3'(c), (c == 0 || c == 7) ? "R3" : "R2");
    // R4: automatic mode with manual codes toggling
    for (int f = 0; f < 4; f++)
      repeat (24) step(1'b1, 2'(f), 2'($urandom), 3'($urandom), "R4");
    // R6: back-to-back switches between extremes, no settling
    repeat (6) begin
      step(1'b0, 2'b00, 2'b10, 3'b001, "R6");
      step(1'b0, 2'b00, 2'b01, 3'b110, "R6");
      step(1'b1, 2'b10, 2'b11, 3'b000, "R6");
    end
    // R6: random mid-stream changes
    begin
      bit a = 1'b1;
      logic [1:0] f = 2'b00, l = 2'b00;
      logic [2:0] c = 3'b011;
      repeat (3000) begin
        if ($urandom_range(7) == 0) begin
          a = 1'($urandom); f = 2'($urandom); l = 2'($urandom); c = 3'($urandom);
        end
        step(a, f, l, c, "R6");
      end
    end
    finish_run();
  end

endmodule